// File: doc/BRIEF.md
# Two-Step Conversion Result Encoder

This block is the digital back end of a two-step (half-flash) analog-to-digital converter. A conversion runs in two phases. In the coarse phase the block takes a thermometer vector from the upper comparator bank and encodes it into the upper result nibble. It then publishes that nibble as the ladder tap to subtract from the input. In the fine phase it encodes a second thermometer vector, taken from the comparators that see the residue, into the lower nibble. It then assembles the full word and pulses a completion flag.

A controller raises `start` and then delivers each sampled comparator vector with its own strobe. A separate comparator above the top of the ladder reports overflow. When it trips during the coarse phase, the word saturates to all ones and the fine phase is skipped. The comparators, the ladder and the analog subtraction sit outside this block.

Top module: `hf_result_encoder`

## Requirements
- R1: After reset `word` is 0, `ovf_n` is 1, and `done`, `busy` and `tap_vld` are 0.
- R2: Each bank vector has 2**NIB_W-1 bits, with bit 0 the lowest comparator. A bit counts as qualified when it is set and its lower neighbour is also set. Bit 0 counts when it is set. The encoded nibble is one plus the index of the highest qualified bit, or 0 when no bit qualifies. An all-ones vector therefore gives all ones, and a stray bit with a clear neighbour below it is ignored.
- R3: In the cycle after a coarse strobe is accepted, `tap_sel` holds the coarse nibble. Without overflow, `tap_vld` is high with `tap_sel` constant until the fine strobe is accepted.
- R4: Without overflow, in the cycle after the fine strobe is accepted, `word[7:4]` is the coarse nibble, `word[3:0]` is the fine nibble, and `ovf_n` is 1.
- R5: `done` is high for exactly one cycle, namely the cycle after the strobe that completes a conversion.
- R6: When `top_cmp` is high at coarse acceptance, the fine phase is skipped. In the next cycle `done` is 1, `word` is all ones and `ovf_n` is 0.
- R7: `start` is ignored while a conversion runs. `coarse_vld` is ignored outside the coarse phase and `fine_vld` outside the fine phase.
- R8: `word` and `ovf_n` change only in a cycle where `done` is high, and hold their values between conversions.
- R9: `busy` is high from the cycle after `start` is accepted until the completing strobe is accepted. `done` is only ever raised right after a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion (accepted when idle) |
| coarse_vld | input | 1 | Strobe for the coarse bank vector |
| coarse_therm | input | 15 | Upper bank thermometer vector |
| top_cmp | input | 1 | High when the input exceeds the top reference |
| fine_vld | input | 1 | Strobe for the fine bank vector |
| fine_therm | input | 15 | Residue bank thermometer vector |
| tap_sel | output | 4 | Ladder tap chosen by the coarse nibble |
| tap_vld | output | 1 | Tap select is valid (fine phase) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| word | output | 8 | Assembled result |
| ovf_n | output | 1 | Overflow, active low, updated with `word` |

## Verification
The bench builds the block with its default nibble width of 4, so each bank has 15 comparators. At this size every one of the 16 levels of each phase can be applied directly, including the empty and full-scale vectors. It also makes it practical to hand-build bubbled vectors whose expected codes are obvious. Tabulated, random and directed conversions together cover overflow saturation and the skipped fine phase, strobes arriving in the wrong phase, and a restart attempted mid-conversion.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic [1:0] {
    HF_IDLE   = 2'd0,
    HF_COARSE = 2'd1,
    HF_FINE   = 2'd2,
    HF_DONE   = 2'd3
  } hf_state_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
  parameter int unsigned NIB_W = 4
) (
  input  logic [(1<<NIB_W)-2:0] therm,
  output logic [NIB_W-1:0]      code
);
  localparam int unsigned THERM_W = (1 << NIB_W) - 1;

  // A comparator counts only if the one below it agrees (bubble rejection)
  logic [THERM_W-1:0] qual;
  assign qual[0] = therm[0];
  for (genvar g = 1; g < THERM_W; g++) begin : g_qual
    assign qual[g] = therm[g] & therm[g-1];
  end

  function automatic logic [NIB_W-1:0] top_index(input logic [THERM_W-1:0] q);
    logic [NIB_W-1:0] r;
    r = '0;
    for (int i = 0; i < THERM_W; i++) begin
      if (q[i]) r = NIB_W'(i + 1);
    end
    return r;
  endfunction

  assign code = top_index(qual);

  always_comb begin
    if (&therm) assert_full_scale_R2: assert (&code);
    if (therm == '0) assert_empty_R2: assert (code == '0);
  end
endmodule

// File: rtl/hf_seq.sv
module hf_seq
  import hf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic coarse_vld,
  input  logic fine_vld,
  input  logic ovf_hit,
  output logic cap_coarse,
  output logic cap_fine,
  output logic busy,
  output logic done,
  output logic tap_vld
);
  hf_state_e state_q, state_d;

  assign cap_coarse = (state_q == HF_COARSE) && coarse_vld;
  assign cap_fine   = (state_q == HF_FINE) && fine_vld;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HF_IDLE:   if (start) state_d = HF_COARSE;
      HF_COARSE: if (coarse_vld) state_d = ovf_hit ? HF_DONE : HF_FINE;
      HF_FINE:   if (fine_vld) state_d = HF_DONE;
      HF_DONE:   state_d = HF_IDLE;
      default:   state_d = HF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HF_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q == HF_COARSE) || (state_q == HF_FINE);
  assign tap_vld = (state_q == HF_FINE);
  assign done    = (state_q == HF_DONE);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
endmodule

// File: rtl/hf_result_encoder.sv
module hf_result_encoder #(
  parameter int unsigned NIB_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   coarse_vld,
  input  logic [(1<<NIB_W)-2:0]  coarse_therm,
  input  logic                   top_cmp,
  input  logic                   fine_vld,
  input  logic [(1<<NIB_W)-2:0]  fine_therm,
  output logic [NIB_W-1:0]       tap_sel,
  output logic                   tap_vld,
  output logic                   busy,
  output logic                   done,
  output logic [2*NIB_W-1:0]     word,
  output logic                   ovf_n
);
  localparam int unsigned WORD_W = 2 * NIB_W;

  logic [NIB_W-1:0]  coarse_code, fine_code;
  logic              cap_coarse, cap_fine;
  logic [NIB_W-1:0]  hi_q;
  logic [WORD_W-1:0] word_q;
  logic              ovf_n_q;

  hf_therm_enc #(.NIB_W(NIB_W)) u_enc_coarse (.therm(coarse_therm), .code(coarse_code));
  hf_therm_enc #(.NIB_W(NIB_W)) u_enc_fine   (.therm(fine_therm),   .code(fine_code));

  hf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coarse_vld(coarse_vld), .fine_vld(fine_vld), .ovf_hit(top_cmp),
    .cap_coarse(cap_coarse), .cap_fine(cap_fine),
    .busy(busy), .done(done), .tap_vld(tap_vld)
  );

  // Coarse nibble doubles as the ladder tap select for the residue phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_q <= '0;
    else if (cap_coarse) hi_q <= coarse_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ovf_n_q <= 1'b1;
    end else if (cap_coarse && top_cmp) begin
      word_q  <= '1;
      ovf_n_q <= 1'b0;
    end else if (cap_fine) begin
      word_q  <= {hi_q, fine_code};
      ovf_n_q <= 1'b1;
    end
  end

  assign tap_sel = hi_q;
  assign word    = word_q;
  assign ovf_n   = ovf_n_q;

  assert_ovf_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_n |-> (word == '1));
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(word) && $stable(ovf_n)));
  assert_tap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_vld && $past(tap_vld)) |-> $stable(tap_sel));
endmodule

// File: tb/test_hf_result_encoder.sv
module test_hf_result_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 100000;
  localparam int NV = 8;
  // {overflow, coarse level, fine level}
  localparam logic [8:0] VEC_TAB [0:NV-1] = '{
    9'h000, 9'h0FF, 9'h05A, 9'h0A5, 9'h010, 9'h001, 9'h13C, 9'h1F0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, coarse_vld = 1'b0, fine_vld = 1'b0, top_cmp = 1'b0;
  logic [14:0] coarse_therm = '0, fine_therm = '0;
  logic [3:0] tap_sel;
  logic tap_vld, busy, done, ovf_n;
  logic [7:0] word;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hf_result_encoder i_hf_result_encoder (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coarse_vld(coarse_vld), .coarse_therm(coarse_therm), .top_cmp(top_cmp),
    .fine_vld(fine_vld), .fine_therm(fine_therm),
    .tap_sel(tap_sel), .tap_vld(tap_vld), .busy(busy), .done(done),
    .word(word), .ovf_n(ovf_n)
  );

  function automatic logic [14:0] level_vec(input int lvl);
    logic [15:0] t;
    t = (16'd1 << lvl) - 16'd1;
    return t[14:0];
  endfunction

  // Reference: scan downward for the first comparator backed by its neighbour
  function automatic int ref_code(input logic [14:0] v);
    for (int i = 14; i >= 0; i--) begin
      if (v[i] && (i == 0 || v[i-1])) return i + 1;
    end
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // One full conversion from idle, checking tap, word and done timing
  task automatic convert(input logic [14:0] cv, input logic ov, input logic [14:0] fv);
    int ec, ef;
    logic [7:0] ew;
    ec = ref_code(cv);
    ef = ref_code(fv);
    ew = ov ? 8'hFF : 8'((ec << 4) | ef);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 busy", int'(busy), 1);
    coarse_therm = cv; top_cmp = ov; coarse_vld = 1'b1;
    @(negedge clk); coarse_vld = 1'b0; top_cmp = 1'b0;
    if (!ov) begin
      chk(tap_vld == 1'b1 && tap_sel == 4'(ec), "R3 tap", int'(tap_sel), ec);
      chk(done == 1'b0, "R5 no early done", int'(done), 0);
      fine_therm = fv; fine_vld = 1'b1;
      @(negedge clk); fine_vld = 1'b0;
      chk(word == ew && ovf_n == 1'b1, "R4 word", int'(word), int'(ew));
    end else begin
      chk(word == 8'hFF && ovf_n == 1'b0, "R6 saturate", int'(word), 255);
    end
    chk(done == 1'b1 && busy == 1'b0, "R5 done", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", int'(done), 0);
    chk(word == ew, "R8 hold", int'(word), int'(ew));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    chk(word == 8'h00 && ovf_n == 1'b1, "R1 word/ovf_n", int'(word), 0);
    chk(done == 1'b0 && busy == 1'b0 && tap_vld == 1'b0, "R1 flags",
        int'({done, busy, tap_vld}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      convert(level_vec(int'(VEC_TAB[k][7:4])), VEC_TAB[k][8], level_vec(int'(VEC_TAB[k][3:0])));
    end
    for (int k = 0; k < 20; k++) begin
      convert(level_vec($urandom_range(0, 15)), 1'b0, level_vec($urandom_range(0, 15)));
    end

    // R2 bubbled vectors: bits 0,1,2,5 -> 3 ; bit 1 alone -> 0 ; hole at bit 3 -> 7
    chk(ref_code(15'h0027) == 3, "R2 ref self", ref_code(15'h0027), 3);
    convert(15'h0027, 1'b0, 15'h0002);
    chk(word == 8'h30, "R2 bubble", int'(word), 8'h30);
    convert(15'h0077, 1'b0, 15'h7FFF);
    chk(word == 8'h7F, "R2 hole", int'(word), 8'h7F);

    // R7 strobes in idle are ignored
    keep = word;
    @(negedge clk); fine_vld = 1'b1; coarse_vld = 1'b1; fine_therm = '0; coarse_therm = '0;
    @(negedge clk); fine_vld = 1'b0; coarse_vld = 1'b0;
    chk(done == 1'b0 && busy == 1'b0 && word == keep, "R7 idle strobes", int'(word), int'(keep));

    // R7 restart and wrong-phase coarse strobe during a conversion
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    coarse_therm = level_vec(9); coarse_vld = 1'b1;
    @(negedge clk); coarse_vld = 1'b0;
    chk(tap_sel == 4'd9 && tap_vld, "R7 restart ignored", int'(tap_sel), 9);
    coarse_therm = level_vec(2); coarse_vld = 1'b1;
    @(negedge clk); coarse_vld = 1'b0; start = 1'b0;
    chk(tap_sel == 4'd9 && tap_vld, "R7 coarse in fine", int'(tap_sel), 9);
    fine_therm = level_vec(4); fine_vld = 1'b1;
    @(negedge clk); fine_vld = 1'b0;
    chk(word == 8'h94 && done, "R4 after ignores", int'(word), 8'h94);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R7 back to idle", int'(busy), 0);

    // R8 overflow flag clears on the next normal conversion
    convert(level_vec(15), 1'b1, '0);
    convert(level_vec(1), 1'b0, level_vec(0));
    chk(ovf_n == 1'b1 && word == 8'h10, "R8 ovf cleared", int'(word), 8'h10);

    summary();
    $finish;
  end
endmodule